// File: doc/BRIEF.md
# Time-of-Day Alarm Match Unit

This block decides, once per second, whether the current time of day equals a programmed alarm time. At every update-ended strobe it compares the seconds, minutes and hours bytes of the clock against three alarm bytes and produces a one-cycle match pulse for the interrupt flag logic. The strobe arrives after the time fields have already advanced, so the pulse marks the second that equals the alarm.

Any alarm byte can be made a "don't care" by setting both of its two top bits. That field then matches any current value, so any subset of the three fields can be left open. With all three open, the alarm fires on every update. Non-wildcard fields are decoded as BCD or as binary, following the data-mode input. Hours are brought to a common 0..23 scale under the 12-hour or 24-hour setting before the comparison. While the clock is frozen for setting, no match is reported. A second output carries the match as an interrupt request, gated by the alarm-enable input.

Top module: `alarm_match_unit`

## Requirements
- R1: After reset is released, match_o and irq_o are 0.
- R2: When upd_strobe_i is 1, set_mode_i is 0 and all three fields match, match_o is 1 in the cycle after the strobe edge and 0 again one cycle later.
- R3: A mismatch in any one non-wildcard field (seconds, minutes or hours) gives no match pulse.
- R4: An alarm byte with bits 7 and 6 both 1 (0xC0..0xFF) matches any current value of its field. With all three alarm bytes in that range, every strobe gives a match.
- R5: With bin_mode_i = 0, field bytes are BCD: bits 6:4 hold the tens digit and bits 3:0 hold the units digit.
- R6: With bin_mode_i = 1, field bytes are plain binary in bits 6:0. For example, 0x3B is 59 and differs from the byte 0x59.
- R7: With h24_mode_i = 0, hour bit 7 set means PM and bits 6:0 hold 1..12. 12 AM becomes hour 0 and 12 PM becomes hour 12. Alarm and current hours are normalised the same way. With h24_mode_i = 1, bits 6:0 hold 0..23.
- R8: While set_mode_i is 1, a strobe gives no match pulse.
- R9: Without a strobe there is no match pulse, whatever the field values.
- R10: irq_o pulses together with match_o only if alarm_en_i was 1 at the strobe. match_o does not depend on alarm_en_i.
- R11: Alarm bytes are looked at only at a strobe. Changing them between strobes has no effect on the outputs, and the new values decide the next strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| upd_strobe_i | input | 1 | Update-ended strobe, one cycle per second |
| set_mode_i | input | 1 | Clock frozen for setting; blocks matches |
| bin_mode_i | input | 1 | 1 = binary fields, 0 = BCD fields |
| h24_mode_i | input | 1 | 1 = 24-hour, 0 = 12-hour with PM in bit 7 |
| alarm_en_i | input | 1 | Alarm interrupt enable |
| cur_sec_i | input | 8 | Current seconds byte |
| cur_min_i | input | 8 | Current minutes byte |
| cur_hour_i | input | 8 | Current hours byte |
| alm_sec_i | input | 8 | Alarm seconds byte |
| alm_min_i | input | 8 | Alarm minutes byte |
| alm_hour_i | input | 8 | Alarm hours byte |
| match_o | output | 1 | Alarm match pulse (alarm flag set) |
| irq_o | output | 1 | Match pulse gated by alarm enable |

## Verification
A vector table exercises the comparator in several ways:
- exact matches in BCD and in binary;
- a single mismatch in each field in turn, which shows that every field takes part in the comparison;
- wildcards in one field, in two or three fields, and a wildcard next to a real mismatch, which shows that a wildcard opens only its own field;
- 12-hour cases that differ only in the PM bit, and the 12 AM / 12 PM pair, which show that normalisation keeps those hours apart.

Directed cases then cover set mode, the absence of a strobe, enable gating, pulse width, and an alarm change made between strobes.

// File: rtl/alarm_match_pkg.sv
package alarm_match_pkg;
  localparam int unsigned DATA_W     = 8;
  localparam int unsigned NUM_FIELDS = 3;
  localparam int unsigned VAL_W      = DATA_W - 1;

  typedef enum logic [1:0] {
    FLD_SEC  = 2'd0,
    FLD_MIN  = 2'd1,
    FLD_HOUR = 2'd2
  } field_e;
endpackage

// File: rtl/alarm_field_dec.sv
module alarm_field_dec #(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned VAL_W = DATA_W - 1
) (
  input  logic [DATA_W-1:0] raw_i,
  input  logic              bin_mode_i,
  output logic [VAL_W-1:0]  val_o,
  output logic              wild_o
);
  logic [VAL_W-1:0] tens, units;

  assign wild_o = &raw_i[DATA_W-1 -: 2];

  always_comb begin
    tens  = VAL_W'(raw_i[VAL_W-1:4]);
    units = VAL_W'(raw_i[3:0]);
    if (bin_mode_i) val_o = raw_i[VAL_W-1:0];
    else            val_o = (tens << 3) + (tens << 1) + units;
  end
endmodule

// File: rtl/alarm_hour_norm.sv
module alarm_hour_norm #(
  parameter int unsigned VAL_W = 7
) (
  input  logic [VAL_W-1:0] val_i,
  input  logic             pm_i,
  input  logic             h24_mode_i,
  output logic [VAL_W-1:0] hour_o
);
  logic [VAL_W-1:0] base;

  always_comb begin
    base = (val_i == VAL_W'(12)) ? '0 : val_i;
    if (h24_mode_i)  hour_o = val_i;
    else if (pm_i)   hour_o = base + VAL_W'(12);
    else             hour_o = base;
  end
endmodule

// File: rtl/alarm_match_unit.sv
module alarm_match_unit
  import alarm_match_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              upd_strobe_i,
  input  logic              set_mode_i,
  input  logic              bin_mode_i,
  input  logic              h24_mode_i,
  input  logic              alarm_en_i,
  input  logic [DATA_W-1:0] cur_sec_i,
  input  logic [DATA_W-1:0] cur_min_i,
  input  logic [DATA_W-1:0] cur_hour_i,
  input  logic [DATA_W-1:0] alm_sec_i,
  input  logic [DATA_W-1:0] alm_min_i,
  input  logic [DATA_W-1:0] alm_hour_i,
  output logic              match_o,
  output logic              irq_o
);
  logic [DATA_W-1:0] cur_raw [NUM_FIELDS];
  logic [DATA_W-1:0] alm_raw [NUM_FIELDS];
  logic [VAL_W-1:0]  cur_val [NUM_FIELDS];
  logic [VAL_W-1:0]  alm_val [NUM_FIELDS];
  logic [VAL_W-1:0]  cur_cmp [NUM_FIELDS];
  logic [VAL_W-1:0]  alm_cmp [NUM_FIELDS];
  logic [NUM_FIELDS-1:0] alm_wild, cur_wild_unused, fld_ok;
  logic hit, fire, match_q, irq_q;

  assign cur_raw[FLD_SEC]  = cur_sec_i;
  assign cur_raw[FLD_MIN]  = cur_min_i;
  assign cur_raw[FLD_HOUR] = cur_hour_i;
  assign alm_raw[FLD_SEC]  = alm_sec_i;
  assign alm_raw[FLD_MIN]  = alm_min_i;
  assign alm_raw[FLD_HOUR] = alm_hour_i;

  for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_fld
    alarm_field_dec #(.DATA_W(DATA_W)) u_cur_dec (
      .raw_i(cur_raw[f]), .bin_mode_i(bin_mode_i),
      .val_o(cur_val[f]), .wild_o(cur_wild_unused[f])
    );
    alarm_field_dec #(.DATA_W(DATA_W)) u_alm_dec (
      .raw_i(alm_raw[f]), .bin_mode_i(bin_mode_i),
      .val_o(alm_val[f]), .wild_o(alm_wild[f])
    );
    if (f == FLD_HOUR) begin : g_hour
      alarm_hour_norm #(.VAL_W(VAL_W)) u_cur_hn (
        .val_i(cur_val[f]), .pm_i(cur_raw[f][DATA_W-1]),
        .h24_mode_i(h24_mode_i), .hour_o(cur_cmp[f])
      );
      alarm_hour_norm #(.VAL_W(VAL_W)) u_alm_hn (
        .val_i(alm_val[f]), .pm_i(alm_raw[f][DATA_W-1]),
        .h24_mode_i(h24_mode_i), .hour_o(alm_cmp[f])
      );
    end else begin : g_plain
      assign cur_cmp[f] = cur_val[f];
      assign alm_cmp[f] = alm_val[f];
    end
    assign fld_ok[f] = alm_wild[f] | (alm_cmp[f] == cur_cmp[f]);
  end

  assign hit  = &fld_ok;
  assign fire = upd_strobe_i & ~set_mode_i & hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      match_q <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      match_q <= fire;
      irq_q   <= fire & alarm_en_i;
    end
  end

  assign match_o = match_q;
  assign irq_o   = irq_q;

  p_no_strobe_no_match_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_strobe_i |=> !match_o);
  p_set_blocks_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_strobe_i && set_mode_i) |=> !match_o);
  p_all_wild_fires_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_strobe_i && !set_mode_i && (&alm_sec_i[7:6]) && (&alm_min_i[7:6])
     && (&alm_hour_i[7:6])) |=> match_o);
  p_irq_implies_match_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> match_o);
  p_irq_gated_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_strobe_i && !alarm_en_i) |=> !irq_o);
endmodule

// File: tb/sim_alarm_match_unit.sv
module sim_alarm_match_unit;
  logic clk = 1'b0, rst_n = 1'b0;
  logic strobe = 0, set_m = 0, bin_m = 0, h24_m = 1, en = 1;
  logic [7:0] cs = 0, cm = 0, ch = 0, as_ = 0, am = 0, ah = 0;
  logic match, irq;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  alarm_match_unit u0 (
    .clk_i(clk), .rst_ni(rst_n), .upd_strobe_i(strobe), .set_mode_i(set_m),
    .bin_mode_i(bin_m), .h24_mode_i(h24_m), .alarm_en_i(en),
    .cur_sec_i(cs), .cur_min_i(cm), .cur_hour_i(ch),
    .alm_sec_i(as_), .alm_min_i(am), .alm_hour_i(ah),
    .match_o(match), .irq_o(irq)
  );

  // {bin, h24, cur s/m/h, alarm s/m/h, expected}
  localparam int NV = 16;
  localparam logic [50:0] VEC [NV] = '{
    {1'b0,1'b1,8'h59,8'h30,8'h23,8'h59,8'h30,8'h23,1'b1},
    {1'b0,1'b1,8'h59,8'h30,8'h23,8'h58,8'h30,8'h23,1'b0},
    {1'b0,1'b1,8'h59,8'h30,8'h23,8'h59,8'h31,8'h23,1'b0},
    {1'b0,1'b1,8'h59,8'h30,8'h23,8'h59,8'h30,8'h22,1'b0},
    {1'b0,1'b1,8'h17,8'h30,8'h23,8'hC0,8'h30,8'h23,1'b1},
    {1'b0,1'b1,8'h05,8'h44,8'h10,8'h05,8'hFF,8'h10,1'b1},
    {1'b0,1'b1,8'h05,8'h44,8'h10,8'h06,8'h44,8'hD5,1'b0},
    {1'b0,1'b1,8'h42,8'h07,8'h19,8'hE3,8'hC7,8'hFF,1'b1},
    {1'b0,1'b1,8'h00,8'h00,8'h00,8'h00,8'h00,8'h00,1'b1},
    {1'b1,1'b1,8'h3B,8'h1E,8'h17,8'h3B,8'h1E,8'h17,1'b1},
    {1'b1,1'b1,8'h3B,8'h1E,8'h17,8'h59,8'h1E,8'h17,1'b0},
    {1'b0,1'b0,8'h00,8'h00,8'h81,8'h00,8'h00,8'h01,1'b0},
    {1'b0,1'b0,8'h00,8'h00,8'h92,8'h00,8'h00,8'h92,1'b1},
    {1'b0,1'b0,8'h00,8'h00,8'h12,8'h00,8'h00,8'h92,1'b0},
    {1'b1,1'b0,8'h00,8'h00,8'h8C,8'h00,8'h00,8'h8C,1'b1},
    {1'b0,1'b0,8'h30,8'h15,8'h87,8'h30,8'h15,8'hC0,1'b1}
  };
  localparam string TAG [NV] = '{
    "R2","R3","R3","R3","R4","R4","R4","R4",
    "R5","R6","R6","R7","R7","R7","R7","R7"
  };

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic pulse_strobe();
    strobe = 1'b1;
    @(negedge clk);
    strobe = 1'b0;
  endtask

  task automatic load(input logic [50:0] v);
    {bin_m, h24_m, cs, cm, ch, as_, am, ah} = v[50:1];
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 match", match, 1'b0);
    check("R1 irq", irq, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 match after release", match, 1'b0);

    for (int i = 0; i < NV; i++) begin
      load(VEC[i]);
      set_m = 0; en = 1;
      pulse_strobe();
      check({TAG[i], " match"}, match, VEC[i][0]);
      check({TAG[i], " irq"}, irq, VEC[i][0]);
      @(negedge clk);
    end

    // R2 pulse width
    load(VEC[0]);
    pulse_strobe();
    check("R2 pulse", match, 1'b1);
    @(negedge clk);
    check("R2 width", match, 1'b0);

    // R9 matching fields, no strobe
    repeat (3) begin
      @(negedge clk);
      check("R9 no strobe", match, 1'b0);
    end

    // R8 set mode
    set_m = 1;
    pulse_strobe();
    check("R8 set blocks", match, 1'b0);
    set_m = 0;
    @(negedge clk);

    // R10 enable gating
    en = 0;
    pulse_strobe();
    check("R10 match without enable", match, 1'b1);
    check("R10 irq without enable", irq, 1'b0);
    en = 1;
    @(negedge clk);

    // R11 alarm change between strobes
    as_ = 8'h11;
    pulse_strobe();
    check("R11 old alarm mismatch", match, 1'b0);
    as_ = 8'h59;
    repeat (2) begin
      @(negedge clk);
      check("R11 change without strobe", match, 1'b0);
    end
    pulse_strobe();
    check("R11 new alarm used", match, 1'b1);
    check("R11 irq", irq, 1'b1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule